// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a register-programmed interval timer. An up-counter advances on a divided copy of the system clock. When the count reaches a programmed compare value, a sticky match flag is set, and a request output can be raised. Software picks the divider, picks 16- or 32-bit counting, and chooses whether the timer halts after the first match or wraps to zero and keeps running. That choice serves both single delays and periodic ticks.

A status bit shows that a counter write is still settling. Software stops the timer, waits for that bit to read 0, and then reprograms the counter. A power-control input freezes the whole timer and keeps its state. Four registers sit on a single-cycle read/write bus:

| Offset | Register |
|---|---|
| 0x0 | control/status |
| 0x4 | count |
| 0x8 | compare |
| 0xC | run |

Top module: `cmt_timer`

## Requirements
- R1: After reset, all four registers read 0 and `match_irq` is 0.
- R2: Writing 1 to bit 5 of the run register starts counting and writing 0 stops it. A stopped counter holds its value, and bit 5 reads back what was written.
- R3: The divider field, control bits 2:0, holds a value k. Counting starts from a run-bit write, and after N further clock cycles the count equals floor(N / 2^k). A value of 5 gives one step every 32 cycles.
- R4: A match occurs on a count step in which the count equals the compare value. A match sets the flag, control bit 15. When control bit 8 is 1 (wrap mode), a match also reloads the count with 0 and counting continues, so the period is compare+1 steps.
- R5: When control bit 8 is 0 (single mode), a match leaves the count at the compare value and clears run bit 5.
- R6: When control bit 9 is 1, the counter is 16 bits wide. It wraps from 0xFFFF to 0, its upper 16 bits read as 0, and only the low 16 bits of the compare value take part in a match.
- R7: The flag is cleared only by a write of 0 to control bit 15 that comes after a read showing the flag as 1. Writing 1 to bit 15, or writing 0 without such a read first, leaves the flag set.
- R8: After a count-register write, control bit 13 reads 1 for exactly 2·2^k clock cycles, where k is the divider value.
- R9: `match_irq` is 1 exactly when the flag is set and the request-enable bit, control bit 4, is 1.
- R10: While `mod_stop` is 1, the count, flags and registers do not change, and bus writes are ignored.
- R11: The register offsets are 0x0 control, 0x4 count, 0x8 compare and 0xC run. A count write takes effect at once, even while running, and takes precedence over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_stop | input | 1 | Module stop; freezes all timer state while 1 |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| match_irq | output | 1 | Match request |

## Verification
A divider that runs out of phase shows up in the count read back tens of cycles after a start, as an off-by-one multiple of the step. A compare fault appears within one step of the expected match, either as a flag that rises a cycle early or late, or as a count that neither holds nor wraps. A write-pending counter with a wrong length shows in bit 13 on the cycle it drops, which the bench samples on both sides of the edge. Frozen-state bugs show as a count or run bit that has moved across a `mod_stop` window.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam logic [3:0] A_CTL = 4'h0;
  localparam logic [3:0] A_CNT = 4'h4;
  localparam logic [3:0] A_CMP = 4'h8;
  localparam logic [3:0] A_RUN = 4'hC;

  localparam int B_FLAG = 15;
  localparam int B_PEND = 13;
  localparam int B_SIZE = 9;
  localparam int B_MODE = 8;
  localparam int B_REQ  = 4;
  localparam int B_RUN  = 5;

  typedef struct packed {
    logic size16;
    logic wrap;
    logic req_en;
  } ctl_t;

  // all-ones mask of the low k bits: divider phase at which a step fires
  function automatic logic [31:0] presc_mask(input int unsigned k);
    return (32'd1 << k) - 32'd1;
  endfunction

  function automatic logic [31:0] width_mask(input logic size16);
    return size16 ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] next_count(input logic [31:0] c, input logic size16);
    return (c + 32'd1) & width_mask(size16);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             active,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  import cmt_pkg::*;
  localparam int PW = (1 << CKS_W) - 1;

  logic [PW-1:0] phase_q;
  logic [31:0]   mask32;

  assign mask32 = presc_mask(int'(cks));
  assign tick   = en && active && ((phase_q & mask32[PW-1:0]) == mask32[PW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (en)  phase_q <= active ? phase_q + 1'b1 : '0;
  end
endmodule

// File: rtl/cmt_pend.sv
module cmt_pend #(
  parameter int PEND_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int PW = $clog2(PEND_TICKS + 1);
  localparam logic [PW-1:0] START = PW'(PEND_TICKS);

  logic [PW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else if (en) begin
      if (load)              left_q <= START;
      else if (tick && busy) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        run,
  input  logic        tick,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [31:0] cmp,
  input  logic        size16,
  input  logic        wrap,
  output logic [31:0] cnt_q,
  output logic        step,
  output logic        match_evt
);
  import cmt_pkg::*;

  logic [31:0] wm;
  logic        equal;

  assign wm        = width_mask(size16);
  assign equal     = ((cnt_q & wm) == (cmp & wm));
  assign step      = run && tick && !wr;
  assign match_evt = step && equal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (en) begin
      if (wr)                     cnt_q <= wdata;
      else if (match_evt && wrap) cnt_q <= '0;
      else if (step && !equal)    cnt_q <= next_count(cnt_q, size16);
    end
  end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int CKS_W      = 3,
  parameter int PEND_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mod_stop,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        match_irq
);
  import cmt_pkg::*;

  logic             en;
  logic             ctl_wr, cnt_wr, cmp_wr, run_wr, ctl_rd;
  logic             ctl_wr_zero;
  logic             run_q, flag_q, seen_q;
  ctl_t             ctl_q;
  logic [CKS_W-1:0] cks_q;
  logic [31:0]      cmp_q, cnt_q;
  logic             tick, step, match_evt, pend_busy, clear_evt;

  assign en          = !mod_stop;
  assign ctl_wr      = en && bus_sel && bus_wr && (bus_addr == A_CTL);
  assign cnt_wr      = en && bus_sel && bus_wr && (bus_addr == A_CNT);
  assign cmp_wr      = en && bus_sel && bus_wr && (bus_addr == A_CMP);
  assign run_wr      = en && bus_sel && bus_wr && (bus_addr == A_RUN);
  assign ctl_rd      = en && bus_sel && !bus_wr && (bus_addr == A_CTL);
  assign ctl_wr_zero = ctl_wr && !bus_wdata[B_FLAG];
  assign clear_evt   = ctl_wr_zero && seen_q && !match_evt;

  cmt_prescaler #(.CKS_W(CKS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .active(run_q || pend_busy), .cks(cks_q), .tick(tick)
  );

  cmt_pend #(.PEND_TICKS(PEND_TICKS)) u_pend (
    .clk(clk), .rst_n(rst_n), .en(en),
    .load(cnt_wr), .tick(tick), .busy(pend_busy)
  );

  cmt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run_q), .tick(tick),
    .wr(cnt_wr), .wdata(bus_wdata), .cmp(cmp_q),
    .size16(ctl_q.size16), .wrap(ctl_q.wrap),
    .cnt_q(cnt_q), .step(step), .match_evt(match_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      seen_q <= 1'b0;
      ctl_q  <= '0;
      cks_q  <= '0;
      cmp_q  <= '0;
    end else if (en) begin
      if (run_wr)                     run_q <= bus_wdata[B_RUN];
      else if (match_evt && !ctl_q.wrap) run_q <= 1'b0;

      if (match_evt)      flag_q <= 1'b1;
      else if (clear_evt) flag_q <= 1'b0;

      if (clear_evt)              seen_q <= 1'b0;
      else if (ctl_rd && flag_q)  seen_q <= 1'b1;

      if (ctl_wr) begin
        ctl_q.size16 <= bus_wdata[B_SIZE];
        ctl_q.wrap   <= bus_wdata[B_MODE];
        ctl_q.req_en <= bus_wdata[B_REQ];
        cks_q        <= bus_wdata[CKS_W-1:0];
      end
      if (cmp_wr) cmp_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[B_FLAG]    = flag_q;
        bus_rdata[B_PEND]    = pend_busy;
        bus_rdata[B_SIZE]    = ctl_q.size16;
        bus_rdata[B_MODE]    = ctl_q.wrap;
        bus_rdata[B_REQ]     = ctl_q.req_en;
        bus_rdata[CKS_W-1:0] = cks_q;
      end
      A_CNT:   bus_rdata = cnt_q & width_mask(ctl_q.size16);
      A_CMP:   bus_rdata = cmp_q;
      A_RUN:   bus_rdata[B_RUN] = run_q;
      default: bus_rdata = '0;
    endcase
  end

  assign match_irq = flag_q && ctl_q.req_en;
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mod_stop,
  input logic        match_evt,
  input logic        wrap,
  input logic        size16,
  input logic        step,
  input logic        run_q,
  input logic        flag_q,
  input logic [31:0] cnt_q,
  input logic        pend_busy,
  input logic        cnt_wr,
  input logic        run_wr,
  input logic        ctl_wr_zero,
  input logic        match_irq
);
  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stop |=> $stable(cnt_q) && $stable(flag_q) && $stable(run_q));

  // R5
  single_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !wrap && !run_wr) |=> !run_q && $stable(cnt_q));

  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && wrap) |=> (cnt_q == 32'd0) && flag_q);

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> flag_q);

  // R8
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_busy) |-> $past(cnt_wr));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctl_wr_zero));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(cnt_q));

  // R6
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size16 && step && !match_evt) |=> (cnt_q[31:16] == 16'd0));
endmodule

bind cmt_timer cmt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_stop(mod_stop), .match_evt(match_evt),
  .wrap(ctl_q.wrap), .size16(ctl_q.size16), .step(step), .run_q(run_q),
  .flag_q(flag_q), .cnt_q(cnt_q), .pend_busy(pend_busy), .cnt_wr(cnt_wr),
  .run_wr(run_wr), .ctl_wr_zero(ctl_wr_zero), .match_irq(match_irq)
);

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
  localparam logic [3:0] CTL = 4'h0, CNT = 4'h4, CMP = 4'h8, RUN = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_stop = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        match_irq;
  int n_chk = 0;
  int n_err = 0;

  cmt_timer dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called and returning at a falling edge; one rising edge in between
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_quiet();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(CTL, v);
      if (!v[13]) break;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(CTL, v); chk("R1 ctl", v, 0);
    rd(CNT, v); chk("R1 cnt", v, 0);
    rd(CMP, v); chk("R1 cmp", v, 0);
    rd(RUN, v); chk("R1 run", v, 0);
    chk("R1 irq", 32'(match_irq), 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(CMP, 32'hFFFF_FFFF);
    wr(CTL, 32'h5); wr(CNT, 0); wait_quiet();
    wr(RUN, 32'h20);
    repeat (100) @(negedge clk);
    rd(CNT, v); chk("R3 div32", v, 3);
    rd(RUN, v); chk("R2 run bit", v, 32'h20);
    wr(RUN, 0);
    wr(CTL, 32'h2); wr(CNT, 0); wait_quiet();
    wr(RUN, 32'h20);
    repeat (37) @(negedge clk);
    rd(CNT, v); chk("R3 div4", v, 9);
    wr(RUN, 0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(CTL, 0); wr(CNT, 0); wait_quiet();
    wr(RUN, 32'h20);
    repeat (10) @(negedge clk);
    wr(RUN, 0);
    rd(CNT, v); chk("R2 stop value", v, 11);
    repeat (5) @(negedge clk);
    rd(CNT, v); chk("R2 held", v, 11);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(CTL, 32'h100); wr(CMP, 4); wr(CNT, 0); wait_quiet();
    wr(RUN, 32'h20);
    repeat (4) @(negedge clk);
    rd(CTL, v); chk("R4 no flag yet", v, 32'h100);
    rd(CTL, v); chk("R4 flag", v, 32'h8100);
    rd(CNT, v); chk("R4 reload", v, 1);
    chk("R9 irq masked", 32'(match_irq), 0);
    wr(RUN, 0);
    wr(CTL, 32'h100);
    rd(CTL, v); chk("R7 cleared", v, 32'h100);
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(CTL, 32'h10); wr(CMP, 3); wr(CNT, 0); wait_quiet();
    wr(RUN, 32'h20);
    repeat (10) @(negedge clk);
    rd(CNT, v); chk("R5 held at cmp", v, 3);
    rd(RUN, v); chk("R5 run cleared", v, 0);
    chk("R9 irq", 32'(match_irq), 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(CTL, 32'h10);
    rd(CTL, v); chk("R7 no read first", v, 32'h8010);
    wr(CTL, 32'h8010);
    rd(CTL, v); chk("R7 write one", v, 32'h8010);
    wr(CTL, 32'h10);
    rd(CTL, v); chk("R7 clear", v, 32'h10);
    chk("R9 irq low", 32'(match_irq), 0);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    wr(CTL, 32'h300); wr(CNT, 32'h1234_FFFE); wait_quiet();
    rd(CNT, v); chk("R6 upper zero", v, 32'h0000_FFFE);
    wr(CMP, 32'h7777_0002);
    @(negedge clk);
    wr(RUN, 32'h20);
    rd(CNT, v); chk("R6 n0", v, 32'hFFFE);
    rd(CNT, v); chk("R6 n1", v, 32'hFFFF);
    rd(CNT, v); chk("R6 wrap", v, 0);
    repeat (2) @(negedge clk);
    rd(CTL, v); chk("R6 low cmp match", v, 32'h8300);
    rd(CNT, v); chk("R6 reload", v, 1);
    wr(RUN, 0);
    wr(CTL, 32'h300);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(CTL, 32'h1);
    @(negedge clk);
    wr(CNT, 32'h55);
    rd(CTL, v); chk("R8 set", v, 32'h2001);
    repeat (2) @(negedge clk);
    rd(CTL, v); chk("R8 last cycle", v, 32'h2001);
    rd(CTL, v); chk("R8 dropped", v, 32'h1);
    rd(CNT, v); chk("R11 cnt write", v, 32'h55);
  endtask

  task automatic t_prio_and_stop();
    logic [31:0] v;
    wr(CTL, 32'h100); wr(CMP, 32'hFFFF_FFFF); wr(CNT, 0); wait_quiet();
    wr(RUN, 32'h20);
    repeat (5) @(negedge clk);
    wr(CNT, 100);
    rd(CNT, v); chk("R11 write while running", v, 100);
    rd(CMP, v); chk("R11 cmp map", v, 32'hFFFF_FFFF);
    rd(CNT, v); chk("R11 counts on", v, 102);
    mod_stop = 1'b1;
    rd(CNT, v); chk("R10 frozen", v, 103);
    repeat (5) @(negedge clk);
    wr(CNT, 0);
    wr(RUN, 0);
    rd(CNT, v); chk("R10 write ignored", v, 103);
    rd(RUN, v); chk("R10 run kept", v, 32'h20);
    mod_stop = 1'b0;
    repeat (3) @(negedge clk);
    rd(CNT, v); chk("R10 resumes", v, 106);
    wr(RUN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_stop();
    t_wrap();
    t_single();
    t_clear();
    t_narrow();
    t_pending();
    t_prio_and_stop();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule